// File: doc/BRIEF.md
# Uncacheable Request Merge Buffer

This block holds uncacheable loads and stores sent by the load and store queues until a bus agent has carried them out. It accepts at most one request per cycle. For each request it does one of three things: it opens a new entry, it folds the request into an entry that already covers the same 8-byte block, or it refuses the request. Each entry keeps the command, the physical and virtual address, 64 bits of data, a byte mask, a non-cacheable flag and an attribute tag. Each entry also carries four state bits: occupied, issued, blocked behind a same-block entry, and completed.

Bus traffic is handled elsewhere. The buffer shows its per-entry state bits to an external issuer. It takes two kinds of updates: an issue strobe that marks an entry as sent, and a completion strobe that carries the read data. In the cycle after it accepts a request, the buffer tells the requester which entry it used. It also hands one completed entry back each cycle through a registered return port.

Top module: `uc_merge_buf`

## Requirements
- R1: After reset every entry is free with all state bits clear, `req_ready` is high for any request, and `id_valid` and `out_valid` are low.
- R2: A request whose block address (address bits above bit 2) matches no occupied entry is placed in the lowest-indexed free entry. That entry has only its occupied bit set.
- R3: A request merges into an occupied same-block entry when all of the following hold: both accesses are non-cacheable; cmd and attribute match; the OR of the two masks is a naturally aligned run of 1, 2, 4 or 8 bytes; and the entry is neither issued, completed, nor named by the issue strobe in that cycle. A merge is accepted even when every entry is occupied, and it allocates nothing.
- R4: A merge ORs the masks and replaces entry data byte i (bits 8i+7..8i) wherever mask bit i of the new request is set. It also rewrites the low three address bits to the index of the lowest set bit of the merged mask.
- R5: A request can pass the R3 attribute and mask test against every same-block entry but still be unable to merge. If a same-block entry is issued and not completing this cycle, or is being issued this cycle, the request gets a free entry with occupied and blocked set.
- R6: A request is refused (`req_ready` low, no state change) when a same-block occupied entry fails the attribute and mask test, or when it needs a new entry and none is free.
- R7: The entry index of an accepted request appears on `id_out` with `id_valid` high in the cycle after acceptance. `id_valid` is low after a cycle with no acceptance.
- R8: An issue strobe sets the issued bit of the named entry.
- R9: A completion strobe clears the issued bit of the named entry and sets its completed bit. For a load (cmd 0) it stores `resp_data` as the entry data; for a store (cmd 1) it keeps the data. It also clears the blocked bit of every other occupied entry in the same block.
- R10: Whenever some entry is occupied and completed, one such entry is freed with all state bits cleared. In the next cycle its index, cmd, address, data and mask appear on the return port with `out_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_cmd | input | 1 | 0 load, 1 store |
| req_paddr | input | ADDR_W | Physical address |
| req_vaddr | input | ADDR_W | Virtual address |
| req_data | input | 64 | Store data |
| req_mask | input | 8 | Byte enables |
| req_nc | input | 1 | Non-cacheable access |
| req_attr | input | ATTR_W | Attribute tag |
| id_valid | output | 1 | Entry index report valid |
| id_out | output | IDX_W | Entry used by the accepted request |
| issue_valid | input | 1 | Issue strobe |
| issue_id | input | IDX_W | Entry being issued |
| resp_valid | input | 1 | Completion strobe |
| resp_id | input | IDX_W | Entry completing |
| resp_data | input | 64 | Read data |
| st_valid | output | ENTRIES | Occupied bits |
| st_inflight | output | ENTRIES | Issued bits |
| st_waitsame | output | ENTRIES | Blocked bits |
| st_waitret | output | ENTRIES | Completed bits |
| out_valid | output | 1 | Returned entry valid |
| out_id | output | IDX_W | Returned entry index |
| out_cmd | output | 1 | Returned command |
| out_paddr | output | ADDR_W | Returned physical address |
| out_vaddr | output | ADDR_W | Returned virtual address |
| out_data | output | 64 | Returned data |
| out_mask | output | 8 | Returned byte mask |

## Verification
The bound checker watches the cycle-level rules on every cycle. An empty buffer always accepts. The index report follows each acceptance by exactly one cycle. A completed entry is never also issued, and a return always comes from a completed entry that has just been freed. The bench scenarios are needed for the data-path results: which entry a request lands in, merged masks, data bytes and realigned addresses, the choice between merging, blocked allocation and refusal, load data replaced from the completion while store data stays, and blocked bits cleared by a completion.

// File: rtl/ucm_pkg.sv
package ucm_pkg;

  typedef enum logic [1:0] {
    ENQ_REJECT = 2'd0,
    ENQ_NEW    = 2'd1,
    ENQ_WAIT   = 2'd2,
    ENQ_MERGE  = 2'd3
  } enq_kind_e;

  // true when m is a run of 1, 2, 4 or 8 bytes starting on a multiple of its size
  function automatic logic mask_is_natural(input logic [7:0] m);
    logic ok;
    logic [15:0] pat;
    ok = 1'b0;
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 8; o += (1 << s)) begin
        pat = ((16'd1 << (1 << s)) - 16'd1) << o;
        if (m == pat[7:0]) ok = 1'b1;
      end
    end
    return ok;
  endfunction

  function automatic logic [2:0] lowest_byte(input logic [7:0] m);
    logic [2:0] r;
    r = 3'd0;
    for (int i = 7; i >= 0; i--) begin
      if (m[i]) r = 3'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/ucm_pick_low.sv
module ucm_pick_low #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ucm_enq_decide.sv
module ucm_enq_decide
  import ucm_pkg::*;
#(
  parameter int N  = 4,
  parameter int BW = 29,
  parameter int TW = 2,
  parameter int IW = 2
) (
  input  logic          req_cmd,
  input  logic [BW-1:0] req_blk,
  input  logic [7:0]    req_mask,
  input  logic          req_nc,
  input  logic [TW-1:0] req_attr,
  input  logic [N-1:0]  st_valid,
  input  logic [N-1:0]  st_inflight,
  input  logic [N-1:0]  st_waitret,
  input  logic          ent_cmd  [N],
  input  logic [BW-1:0] ent_blk  [N],
  input  logic [7:0]    ent_mask [N],
  input  logic          ent_nc   [N],
  input  logic [TW-1:0] ent_attr [N],
  input  logic          issue_valid,
  input  logic [IW-1:0] issue_id,
  input  logic          resp_valid,
  input  logic [IW-1:0] resp_id,
  input  logic          free_found,
  input  logic [IW-1:0] free_idx,
  output enq_kind_e     kind,
  output logic [IW-1:0] tgt_idx
);
  logic [N-1:0] can_merge, bad, busy;
  logic         m_found;
  logic [IW-1:0] m_idx;

  always_comb begin
    for (int e = 0; e < N; e++) begin
      logic hit, cond, issuing, closing;
      hit     = st_valid[e] && (ent_blk[e] == req_blk);
      cond    = req_nc && ent_nc[e] && (ent_cmd[e] == req_cmd) &&
                (ent_attr[e] == req_attr) && mask_is_natural(ent_mask[e] | req_mask);
      issuing = issue_valid && (issue_id == IW'(e));
      closing = resp_valid && (resp_id == IW'(e));
      can_merge[e] = hit && cond && !st_inflight[e] && !st_waitret[e] && !issuing;
      bad[e]       = hit && !cond;
      busy[e]      = hit && ((st_inflight[e] && !closing) || issuing);
    end
  end

  ucm_pick_low #(.N(N), .IW(IW)) u_merge_pick (
    .req(can_merge), .found(m_found), .idx(m_idx)
  );

  always_comb begin
    tgt_idx = free_idx;
    if (|bad)             kind = ENQ_REJECT;
    else if (m_found)     begin kind = ENQ_MERGE; tgt_idx = m_idx; end
    else if (!free_found) kind = ENQ_REJECT;
    else if (|busy)       kind = ENQ_WAIT;
    else                  kind = ENQ_NEW;
  end
endmodule

// File: rtl/uc_merge_buf.sv
module uc_merge_buf
  import ucm_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 32,
  parameter int ATTR_W  = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int BLK_W  = ADDR_W - 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_cmd,
  input  logic [ADDR_W-1:0]  req_paddr,
  input  logic [ADDR_W-1:0]  req_vaddr,
  input  logic [63:0]        req_data,
  input  logic [7:0]         req_mask,
  input  logic               req_nc,
  input  logic [ATTR_W-1:0]  req_attr,
  output logic               id_valid,
  output logic [IDX_W-1:0]   id_out,
  input  logic               issue_valid,
  input  logic [IDX_W-1:0]   issue_id,
  input  logic               resp_valid,
  input  logic [IDX_W-1:0]   resp_id,
  input  logic [63:0]        resp_data,
  output logic [ENTRIES-1:0] st_valid,
  output logic [ENTRIES-1:0] st_inflight,
  output logic [ENTRIES-1:0] st_waitsame,
  output logic [ENTRIES-1:0] st_waitret,
  output logic               out_valid,
  output logic [IDX_W-1:0]   out_id,
  output logic               out_cmd,
  output logic [ADDR_W-1:0]  out_paddr,
  output logic [ADDR_W-1:0]  out_vaddr,
  output logic [63:0]        out_data,
  output logic [7:0]         out_mask
);
  // entry payload, no reset
  logic              e_cmd   [ENTRIES];
  logic [ADDR_W-1:0] e_paddr [ENTRIES];
  logic [ADDR_W-1:0] e_vaddr [ENTRIES];
  logic [63:0]       e_data  [ENTRIES];
  logic [7:0]        e_mask  [ENTRIES];
  logic              e_nc    [ENTRIES];
  logic [ATTR_W-1:0] e_attr  [ENTRIES];
  logic [BLK_W-1:0]  e_blk   [ENTRIES];

  logic             free_found, deq_found;
  logic [IDX_W-1:0] free_idx, deq_idx, tgt_idx;
  enq_kind_e        kind;
  logic             accept, do_alloc, do_merge;
  logic [7:0]       mm;
  logic [63:0]      md;
  logic [2:0]       m_low;

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) e_blk[e] = e_paddr[e][ADDR_W-1:3];
  end

  ucm_pick_low #(.N(ENTRIES), .IW(IDX_W)) u_free_pick (
    .req(~st_valid), .found(free_found), .idx(free_idx)
  );

  ucm_pick_low #(.N(ENTRIES), .IW(IDX_W)) u_deq_pick (
    .req(st_valid & st_waitret), .found(deq_found), .idx(deq_idx)
  );

  ucm_enq_decide #(.N(ENTRIES), .BW(BLK_W), .TW(ATTR_W), .IW(IDX_W)) u_decide (
    .req_cmd(req_cmd), .req_blk(req_paddr[ADDR_W-1:3]), .req_mask(req_mask),
    .req_nc(req_nc), .req_attr(req_attr),
    .st_valid(st_valid), .st_inflight(st_inflight), .st_waitret(st_waitret),
    .ent_cmd(e_cmd), .ent_blk(e_blk), .ent_mask(e_mask), .ent_nc(e_nc),
    .ent_attr(e_attr),
    .issue_valid(issue_valid), .issue_id(issue_id),
    .resp_valid(resp_valid), .resp_id(resp_id),
    .free_found(free_found), .free_idx(free_idx),
    .kind(kind), .tgt_idx(tgt_idx)
  );

  assign req_ready = (kind != ENQ_REJECT);
  assign accept    = req_valid && req_ready;
  assign do_alloc  = accept && (kind == ENQ_NEW || kind == ENQ_WAIT);
  assign do_merge  = accept && (kind == ENQ_MERGE);

  // merged view of the target entry
  always_comb begin
    mm = e_mask[tgt_idx] | req_mask;
    for (int b = 0; b < 8; b++) begin
      md[8*b +: 8] = req_mask[b] ? req_data[8*b +: 8] : e_data[tgt_idx][8*b +: 8];
    end
    m_low = lowest_byte(mm);
  end

  always_ff @(posedge clk) begin
    if (do_alloc) begin
      e_cmd[tgt_idx]   <= req_cmd;
      e_paddr[tgt_idx] <= req_paddr;
      e_vaddr[tgt_idx] <= req_vaddr;
      e_data[tgt_idx]  <= req_data;
      e_mask[tgt_idx]  <= req_mask;
      e_nc[tgt_idx]    <= req_nc;
      e_attr[tgt_idx]  <= req_attr;
    end else if (do_merge) begin
      e_mask[tgt_idx]  <= mm;
      e_data[tgt_idx]  <= md;
      e_paddr[tgt_idx] <= {e_paddr[tgt_idx][ADDR_W-1:3], m_low};
      e_vaddr[tgt_idx] <= {e_vaddr[tgt_idx][ADDR_W-1:3], m_low};
    end
    if (resp_valid && !e_cmd[resp_id]) e_data[resp_id] <= resp_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid    <= '0;
      st_inflight <= '0;
      st_waitsame <= '0;
      st_waitret  <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (resp_valid && st_valid[e] && (resp_id != IDX_W'(e)) &&
            (e_blk[e] == e_blk[resp_id]))
          st_waitsame[e] <= 1'b0;
        if (issue_valid && issue_id == IDX_W'(e)) st_inflight[e] <= 1'b1;
        if (resp_valid && resp_id == IDX_W'(e)) begin
          st_inflight[e] <= 1'b0;
          st_waitret[e]  <= 1'b1;
        end
        if (deq_found && deq_idx == IDX_W'(e)) begin
          st_valid[e]    <= 1'b0;
          st_inflight[e] <= 1'b0;
          st_waitsame[e] <= 1'b0;
          st_waitret[e]  <= 1'b0;
        end
        if (do_alloc && tgt_idx == IDX_W'(e)) begin
          st_valid[e]    <= 1'b1;
          st_inflight[e] <= 1'b0;
          st_waitsame[e] <= (kind == ENQ_WAIT);
          st_waitret[e]  <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      id_valid  <= 1'b0;
      id_out    <= '0;
      out_valid <= 1'b0;
      out_id    <= '0;
      out_cmd   <= 1'b0;
      out_paddr <= '0;
      out_vaddr <= '0;
      out_data  <= '0;
      out_mask  <= '0;
    end else begin
      id_valid  <= accept;
      id_out    <= tgt_idx;
      out_valid <= deq_found;
      out_id    <= deq_idx;
      out_cmd   <= e_cmd[deq_idx];
      out_paddr <= e_paddr[deq_idx];
      out_vaddr <= e_vaddr[deq_idx];
      out_data  <= e_data[deq_idx];
      out_mask  <= e_mask[deq_idx];
    end
  end
endmodule

// File: rtl/uc_merge_buf_chk.sv
module uc_merge_buf_chk #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          id_valid,
  input logic          out_valid,
  input logic [IW-1:0] out_id,
  input logic [N-1:0]  st_valid,
  input logic [N-1:0]  st_inflight,
  input logic [N-1:0]  st_waitret
);
  assert_empty_accepts_R1: assert property (@(posedge clk) disable iff (rst)
    (st_valid == '0) |-> req_ready);

  assert_id_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> id_valid);

  assert_no_id_without_accept_R7: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !id_valid);

  assert_done_not_issued_R9: assert property (@(posedge clk) disable iff (rst)
    ((st_waitret & st_inflight) == '0) && ((st_waitret & ~st_valid) == '0));

  assert_return_follows_done_R10: assert property (@(posedge clk) disable iff (rst)
    (|(st_valid & st_waitret)) |=> out_valid);

  assert_return_frees_entry_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !st_valid[out_id]);
endmodule

bind uc_merge_buf uc_merge_buf_chk #(.N(ENTRIES), .IW(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .id_valid(id_valid), .out_valid(out_valid), .out_id(out_id),
  .st_valid(st_valid), .st_inflight(st_inflight), .st_waitret(st_waitret)
);

// File: tb/uc_merge_buf_bench.sv
module uc_merge_buf_bench;
  localparam int N  = 4;
  localparam int AW = 32;
  localparam int TW = 2;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          req_valid = 0, req_ready, req_cmd = 0, req_nc = 0;
  logic [AW-1:0] req_paddr = '0, req_vaddr = '0;
  logic [63:0]   req_data = '0, resp_data = '0;
  logic [7:0]    req_mask = '0;
  logic [TW-1:0] req_attr = '0;
  logic          id_valid, issue_valid = 0, resp_valid = 0;
  logic [IW-1:0] id_out, issue_id = '0, resp_id = '0;
  logic [N-1:0]  st_valid, st_inflight, st_waitsame, st_waitret;
  logic          out_valid, out_cmd;
  logic [IW-1:0] out_id;
  logic [AW-1:0] out_paddr, out_vaddr;
  logic [63:0]   out_data;
  logic [7:0]    out_mask;

  int total = 0;
  int bad = 0;
  bit done = 0;

  uc_merge_buf #(.ENTRIES(N), .ADDR_W(AW), .ATTR_W(TW)) u_uc_merge_buf (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_paddr(req_paddr), .req_vaddr(req_vaddr),
    .req_data(req_data), .req_mask(req_mask), .req_nc(req_nc), .req_attr(req_attr),
    .id_valid(id_valid), .id_out(id_out), .issue_valid(issue_valid),
    .issue_id(issue_id), .resp_valid(resp_valid), .resp_id(resp_id),
    .resp_data(resp_data), .st_valid(st_valid), .st_inflight(st_inflight),
    .st_waitsame(st_waitsame), .st_waitret(st_waitret), .out_valid(out_valid),
    .out_id(out_id), .out_cmd(out_cmd), .out_paddr(out_paddr),
    .out_vaddr(out_vaddr), .out_data(out_data), .out_mask(out_mask)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input logic cmd, input logic nc, input logic [TW-1:0] attr,
                     input logic [AW-1:0] pa, input logic [7:0] m, input logic [63:0] d);
    req_valid = 1; req_cmd = cmd; req_nc = nc; req_attr = attr;
    req_paddr = pa; req_vaddr = pa ^ 32'h8000_0000; req_mask = m; req_data = d;
  endtask

  task automatic idle();
    req_valid = 0; issue_valid = 0; resp_valid = 0;
  endtask

  task automatic t_reset();
    rst = 1; idle();
    repeat (3) step();
    rst = 0;
    put(1'b0, 1'b0, '0, 32'h0, 8'hFF, '0); #1;
    chk("R1 ready", req_ready, 1);
    req_valid = 0;
    chk("R1 valid", st_valid, 0);
    chk("R1 other state", {st_inflight, st_waitsame, st_waitret}, 0);
    chk("R1 id/out", {id_valid, out_valid}, 0);
  endtask

  task automatic t_alloc_merge();
    put(1'b1, 1'b1, 2'd1, 32'h100, 8'h01, 64'h11); #1;
    chk("R2 ready", req_ready, 1);
    step(); idle();
    chk("R7 id_valid", id_valid, 1);
    chk("R2 id", id_out, 0);
    chk("R2 state", {st_valid, st_inflight, st_waitsame, st_waitret}, 16'h1000);
    step();
    chk("R7 id quiet", id_valid, 0);
    put(1'b1, 1'b1, 2'd1, 32'h101, 8'h02, 64'h2200);
    step(); idle();
    chk("R3 merge id", {id_valid, id_out}, {1'b1, 2'd0});
    chk("R3 no alloc", st_valid, 4'b0001);
    put(1'b1, 1'b1, 2'd1, 32'h102, 8'h04, 64'h0); #1;
    chk("R6 misaligned ready", req_ready, 0);
    step(); idle();
    chk("R6 no change", {id_valid, st_valid}, {1'b0, 4'b0001});
    put(1'b0, 1'b0, 2'd0, 32'h208, 8'hFF, 64'h0);
    step(); idle();
    chk("R2 second id", {id_valid, id_out}, {1'b1, 2'd1});
    chk("R2 second valid", st_valid, 4'b0011);
  endtask

  task automatic t_issue_wait();
    issue_valid = 1; issue_id = 2'd0;
    put(1'b1, 1'b1, 2'd1, 32'h104, 8'h0C, 64'h0);
    step(); idle();
    chk("R5 id", {id_valid, id_out}, {1'b1, 2'd2});
    chk("R5 waitsame", st_waitsame, 4'b0100);
    chk("R8 inflight", st_inflight, 4'b0001);
    chk("R5 valid", st_valid, 4'b0111);
  endtask

  task automatic t_load_return();
    issue_valid = 1; issue_id = 2'd1;
    step(); idle();
    chk("R8 inflight two", st_inflight, 4'b0011);
    resp_valid = 1; resp_id = 2'd1; resp_data = 64'hDEAD_BEEF_0123_4567;
    step(); idle();
    chk("R9 waitret", st_waitret, 4'b0010);
    chk("R9 inflight cleared", st_inflight, 4'b0001);
    chk("R10 not yet", out_valid, 0);
    step();
    chk("R10 out", {out_valid, out_id, out_cmd}, {1'b1, 2'd1, 1'b0});
    chk("R9 load data", out_data, 64'hDEAD_BEEF_0123_4567);
    chk("R10 freed", st_valid, 4'b0101);
  endtask

  task automatic t_store_return();
    resp_valid = 1; resp_id = 2'd0; resp_data = 64'hFFFF_FFFF_FFFF_FFFF;
    step(); idle();
    chk("R9 waitsame cleared", st_waitsame, 4'b0000);
    chk("R9 waitret store", st_waitret, 4'b0001);
    step();
    chk("R10 out store", {out_valid, out_id, out_cmd}, {1'b1, 2'd0, 1'b1});
    chk("R4 mask", out_mask, 8'h03);
    chk("R4 addr", out_paddr, 32'h100);
    chk("R9 store data kept", out_data, 64'h2211);
    chk("R10 freed store", st_valid, 4'b0100);
  endtask

  task automatic t_full();
    put(1'b0, 1'b0, 2'd0, 32'h300, 8'hFF, 64'h0); step();
    chk("R2 fill id0", id_out, 0);
    put(1'b0, 1'b0, 2'd0, 32'h400, 8'hFF, 64'h0); step();
    chk("R2 fill id1", id_out, 1);
    put(1'b1, 1'b1, 2'd1, 32'h505, 8'h20, 64'h0000_AB00_0000_0000); step();
    chk("R2 fill id3", id_out, 3);
    chk("R2 full", st_valid, 4'b1111);
    put(1'b0, 1'b0, 2'd0, 32'h600, 8'hFF, 64'h0); #1;
    chk("R6 full ready", req_ready, 0);
    step(); idle();
    chk("R6 full no change", {id_valid, st_valid}, {1'b0, 4'b1111});
    put(1'b1, 1'b1, 2'd1, 32'h504, 8'h10, 64'h0000_00CD_0000_0000); #1;
    chk("R3 merge when full", req_ready, 1);
    step(); idle();
    chk("R3 merge id3", {id_valid, id_out}, {1'b1, 2'd3});
    issue_valid = 1; issue_id = 2'd3; step(); idle();
    resp_valid = 1; resp_id = 2'd3; resp_data = 64'h0; step(); idle();
    step();
    chk("R10 out id3", {out_valid, out_id}, {1'b1, 2'd3});
    chk("R4 merged mask", out_mask, 8'h30);
    chk("R4 realigned addr", out_paddr, 32'h504);
    chk("R4 merged data", out_data, 64'h0000_ABCD_0000_0000);
    chk("R10 freed id3", st_valid, 4'b0111);
  endtask

  task automatic t_attr_reject();
    put(1'b1, 1'b1, 2'd2, 32'h106, 8'h40, 64'h0); #1;
    chk("R6 attr mismatch", req_ready, 0);
    step(); idle();
    chk("R6 attr no change", {id_valid, st_valid}, {1'b0, 4'b0111});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_alloc_merge();
    t_issue_wait();
    t_load_return();
    t_store_return();
    t_full();
    t_attr_reject();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule